// File: doc/BRIEF.md
# Integrating Loss-of-Frame Timer

This block turns a per-frame severely-errored-frame (SEF) indication into a loss-of-frame (LOF) alarm. It is sampled once per frame on a single-cycle frame tick (one tick every 125 us). Between ticks the block does nothing.

Time spent in SEF is integrated rather than measured as one unbroken run. Short SEF-free gaps therefore only pause the count. Intermittent framing trouble still ends in LOF after a total of 3 ms of SEF.

A separate in-frame timer measures continuous SEF-free time:
- A long enough in-frame stretch returns the SEF integration to zero.
- A long enough in-frame stretch also withdraws an active alarm.

All windows are counted in ticks, so the 3 ms figure holds at every line rate. The defaults are 24 ticks for each window.

Top module: `lof_timer`

## Requirements
- R1: While rst_ni is low and after it rises, lof_o is 0 and both the accumulated SEF time and the in-frame time are zero, so a full DECLARE_TICKS of SEF ticks is needed for the first alarm.
- R2: lof_o rises after the clock edge of the tick on which the accumulated count of ticks with sef_i=1 reaches DECLARE_TICKS (default 24, that is 3 ms of 125 us frames).
- R3: In cycles with tick_i=0, sef_i is ignored: lof_o and all accumulated time stay unchanged.
- R4: A run of fewer than RESET_TICKS consecutive ticks with sef_i=0 holds the accumulated SEF count; later SEF ticks add to it.
- R5: RESET_TICKS consecutive ticks with sef_i=0 return the accumulated SEF count to zero.
- R6: An active lof_o clears after the edge of the CLEAR_TICKS-th consecutive tick with sef_i=0. Any tick with sef_i=1 restarts that in-frame count from zero.
- R7: A tick with sef_i=1 never clears lof_o, and a tick with sef_i=0 never sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle frame tick, one per 125 us frame |
| sef_i | input | 1 | SEF flag, sampled only on tick cycles |
| lof_o | output | 1 | Loss-of-frame alarm |

## Verification
The bench sweeps a first SEF burst, then an SEF-free gap, then a second burst, and checks the alarm after every tick. This exposes four kinds of faulty design:
- One that resets the integration on any gap instead of holding it.
- One that holds it forever, or resets it one tick early or late around the 24-tick gap boundary.
- One that declares one tick early or late.
- One whose alarm does not clear on exactly the 24th SEF-free tick, or whose in-frame count survives an intervening SEF tick.

Off-tick cycles drive the opposite SEF level. A design that samples SEF outside tick cycles would therefore alarm or clear at the wrong time.

// File: rtl/lof_pkg.sv
package lof_pkg;
  localparam int unsigned WINDOW_TICKS_DEF = 24;  // 3 ms of 125 us frames

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lof_oof_integ.sv
module lof_oof_integ #(
  parameter int unsigned DECLARE_TICKS = lof_pkg::WINDOW_TICKS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sef_i,
  input  logic wipe_i,
  output logic declare_o
);
  localparam int unsigned CW = $clog2(DECLARE_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DECLARE_TICKS);

  logic [CW-1:0] oof_q, oof_inc;

  // saturate so the alarm re-asserts on every further SEF tick
  assign oof_inc   = (oof_q == LIMIT) ? oof_q : oof_q + CW'(1);
  assign declare_o = tick_i && sef_i && (oof_inc == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oof_q <= '0;
    end else if (tick_i) begin
      if (sef_i)       oof_q <= oof_inc;
      else if (wipe_i) oof_q <= '0;
    end
  end

  p_oof_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oof_q <= LIMIT);
  p_oof_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !sef_i && !wipe_i) |=> $stable(oof_q));
  p_oof_wipe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !sef_i && wipe_i) |=> (oof_q == '0));
  p_oof_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(oof_q));
endmodule

// File: rtl/lof_inframe_timer.sv
module lof_inframe_timer #(
  parameter int unsigned CLEAR_TICKS = lof_pkg::WINDOW_TICKS_DEF,
  parameter int unsigned RESET_TICKS = lof_pkg::WINDOW_TICKS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sef_i,
  output logic clear_o,
  output logic wipe_o
);
  localparam int unsigned SAT = lof_pkg::max_u(CLEAR_TICKS, RESET_TICKS);
  localparam int unsigned CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_C = CW'(SAT);
  localparam logic [CW-1:0] CLR_C = CW'(CLEAR_TICKS);
  localparam logic [CW-1:0] RST_C = CW'(RESET_TICKS);

  logic [CW-1:0] inf_q, inf_inc;
  logic          quiet_tick;

  assign quiet_tick = tick_i && !sef_i;
  assign inf_inc    = (inf_q == SAT_C) ? inf_q : inf_q + CW'(1);
  assign clear_o    = quiet_tick && (inf_inc >= CLR_C);
  assign wipe_o     = quiet_tick && (inf_inc >= RST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inf_q <= '0;
    else if (tick_i) inf_q <= sef_i ? '0 : inf_inc;
  end

  p_inf_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sef_i) |=> (inf_q == '0));
  p_inf_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(inf_q));
  p_inf_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inf_q <= SAT_C);
endmodule

// File: rtl/lof_timer.sv
module lof_timer #(
  parameter int unsigned DECLARE_TICKS = lof_pkg::WINDOW_TICKS_DEF,
  parameter int unsigned CLEAR_TICKS   = lof_pkg::WINDOW_TICKS_DEF,
  parameter int unsigned RESET_TICKS   = lof_pkg::WINDOW_TICKS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sef_i,
  output logic lof_o
);
  logic declare, clear, wipe, lof_q;

  lof_inframe_timer #(
    .CLEAR_TICKS(CLEAR_TICKS),
    .RESET_TICKS(RESET_TICKS)
  ) u_inframe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .sef_i  (sef_i),
    .clear_o(clear),
    .wipe_o (wipe)
  );

  lof_oof_integ #(
    .DECLARE_TICKS(DECLARE_TICKS)
  ) u_oof (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .sef_i    (sef_i),
    .wipe_i   (wipe),
    .declare_o(declare)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lof_q <= 1'b0;
    else if (declare) lof_q <= 1'b1;
    else if (clear)   lof_q <= 1'b0;
  end

  assign lof_o = lof_q;

  p_lof_tick_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(lof_o));
  p_lof_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lof_o) |-> $past(tick_i && sef_i));
  p_lof_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lof_o) |-> $past(tick_i && !sef_i));
  p_lof_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lof_o && tick_i && sef_i) |=> lof_o);
  p_lof_no_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lof_o && tick_i && !sef_i) |=> !lof_o);
  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(declare && clear));
endmodule

// File: tb/lof_timer_test.sv
module lof_timer_test;
  localparam int N = 24;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic sef_i = 1'b0;
  logic lof_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  lof_timer uut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .sef_i (sef_i),
    .lof_o (lof_o)
  );

  always #2 clk_i = ~clk_i;  // 250 MHz

  task automatic chk(input bit exp, input string req, input string what);
    checks++;
    if (lof_o !== exp) begin
      errors++;
      $display("FAIL %s %s: lof_o=%0b expected %0b", req, what, lof_o, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; tick_i = 1'b0; sef_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one tick cycle, then one off-tick cycle driving the opposite SEF level
  task automatic frame(input bit s);
    @(negedge clk_i);
    sef_i = s; tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0; sef_i = ~s;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 190000 && !done) begin
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, cycles=%0d expected <190000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int acc;
    do_reset();
    chk(1'b0, "R1", "after reset");

    // R3: SEF held without ticks must not accumulate
    @(negedge clk_i); sef_i = 1'b1;
    repeat (100) @(negedge clk_i);
    chk(1'b0, "R3", "sef without ticks");

    // R1/R2: exactly N SEF ticks from a clean start
    for (int i = 1; i <= N; i++) begin
      frame(1'b1);
      chk(i >= N, (i >= N) ? "R2" : "R1", $sformatf("sef tick %0d", i));
    end

    // R3: no ticks, SEF low, alarm must hold
    @(negedge clk_i); sef_i = 1'b0;
    repeat (100) @(negedge clk_i);
    chk(1'b1, "R3", "no ticks while alarmed");

    // R6/R7: interrupted in-frame run, then a full one
    for (int i = 1; i < N; i++) frame(1'b0);
    chk(1'b1, "R6", "23 quiet ticks");
    frame(1'b1);
    chk(1'b1, "R7", "sef tick while alarmed");
    for (int i = 1; i <= N; i++) begin
      frame(1'b0);
      chk(i < N, "R6", $sformatf("quiet tick %0d after restart", i));
    end

    // R5: accumulation starts from zero after clearing
    for (int i = 1; i <= N; i++) begin
      frame(1'b1);
      chk(i >= N, "R5", $sformatf("fresh sef tick %0d", i));
    end

    // Sweep: burst a, gap g, burst b (R4, R5, R7, R2)
    for (int a = 0; a <= 26; a++) begin
      for (int gi = 0; gi < 8; gi++) begin
        int g;
        case (gi)
          0: g = 0;  1: g = 1;  2: g = 12; 3: g = 22;
          4: g = 23; 5: g = 24; 6: g = 25; default: g = 30;
        endcase
        do_reset();
        for (int i = 1; i <= a; i++) frame(1'b1);
        chk(a >= N, "R2", $sformatf("a=%0d", a));
        for (int j = 1; j <= g; j++) begin
          frame(1'b0);
          chk((a >= N) && (j < N), "R7", $sformatf("a=%0d gap tick %0d", a, j));
        end
        for (int k = 1; k <= 26; k++) begin
          frame(1'b1);
          acc = ((g >= N) ? 0 : a) + k;
          chk(acc >= N, (g >= N) ? "R5" : "R4", $sformatf("a=%0d g=%0d k=%0d", a, g, k));
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule